// File: doc/BRIEF.md
# Transposed-Form Biquad Recursive Filter

This block is a second-order recursive filter built in transposed form, with every multiply mapped to its own multiplier so that one sample is accepted on every clock that carries one. The sample and all five coefficients (three feedforward, two feedback) are Q1.15 signed values. They come straight from the ports and feed the arithmetic without being registered first, so the path from the ports to the state registers is combinational. A coefficient change takes effect on the very sample that arrives with it.

The block holds two state accumulators at full product precision plus two guard bits. The current sum is `ff0·x + st1`. It is rounded half-up back to Q1.15 and clamped to the 16-bit range. This clamped value is used at once as the feedback operand. It is also captured in a dedicated output register, so the port `y_out` always shows a register and lags the sum by one clock. An input-valid strobe gates every register update. A synchronous active-high reset clears all three registers.

The block has a single operating mode: a register bank that advances on valid samples. It has no sequencer states. The only transitions are hold (valid low), advance (valid high) and clear (reset).

Top module: `biquad_tf_top`

## Requirements
- R1: A synchronous active-high `rst` clears `y_out` and both state accumulators to zero on the next rising edge, overriding `in_vld`. After reset, a zero input gives a zero output.
- R2: On a clock edge with `in_vld` high, `y_out` takes the value Q(ff0·x + st1), where Q is the rounding and saturation of R4 and R5. The value is visible one clock after the sample is presented.
- R3: On the same edge, st1 becomes ff1·x − fb1·y + st2 and st2 becomes ff2·x − fb2·y. Here y is the 16-bit clamped sum of the current sample, not the registered output.
- R4: Rounding from the Q2.30-scaled accumulator to Q1.15 adds 2^14 and then shifts arithmetically right by 15. For example, with ff0 = 1: x = 16384 gives 1, x = 16383 gives 0, and x = −16385 gives −1.
- R5: A rounded sum above 32767 yields 32767 and one below −32768 yields −32768. The output never wraps.
- R6: With `in_vld` low, `y_out` and both accumulators hold their values whatever the sample and coefficient inputs do.
- R7: An input of 32767 followed by zeros produces the filter's impulse response at `y_out`, sample by sample.
- R8: Coefficients are used combinationally: a new coefficient set applies to the sample presented in the same cycle.
- R9: The sample, the coefficients and the products are all signed two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Sample present; gates all register updates |
| x_in | input | 16 | Input sample, Q1.15 signed |
| ff0_c | input | 16 | Feedforward coefficient for the current sample |
| ff1_c | input | 16 | Feedforward coefficient for the one-sample delay |
| ff2_c | input | 16 | Feedforward coefficient for the two-sample delay |
| fb1_c | input | 16 | Feedback coefficient for the one-sample delay (subtracted) |
| fb2_c | input | 16 | Feedback coefficient for the two-sample delay (subtracted) |
| y_out | output | 16 | Registered filtered output, Q1.15 signed |

## Verification
The first stimulus is a full-scale impulse followed by zeros through a stable coefficient set. This separates a correct transposed recursion from one that uses the wrong feedback tap or the registered output. Next come stretches with the strobe low while sample and coefficient inputs churn, which show whether any register leaks an update. Hand-picked samples that fall just either side of the rounding threshold, and extreme products that push the sum past both rails, separate half-up rounding from truncation and clamping from wrap-around. Long runs of random signed samples, with coefficients that change on every cycle, check that coefficients act combinationally and that the signed arithmetic holds everywhere.

// File: rtl/biquad_pkg.sv
package biquad_pkg;
    parameter int unsigned DEF_DATA_W  = 16;
    parameter int unsigned DEF_FRAC_W  = 15;
    parameter int unsigned DEF_GUARD_W = 2;
endpackage

// File: rtl/biquad_mac.sv
module biquad_mac #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ACC_W  = 34,
    parameter bit          NEGATE = 1'b0
) (
    input  logic signed [DATA_W-1:0] op_a,
    input  logic signed [DATA_W-1:0] op_b,
    input  logic signed [ACC_W-1:0]  addend,
    output logic signed [ACC_W-1:0]  acc_out
);
    localparam int unsigned PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;

    always_comb begin
        prod     = op_a * op_b;
        prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    end

    generate
        if (NEGATE) begin : g_sub
            assign acc_out = addend - prod_ext;
        end else begin : g_add
            assign acc_out = addend + prod_ext;
        end
    endgenerate
endmodule

// File: rtl/biquad_quant.sv
module biquad_quant #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned FRAC_W = 15,
    parameter int unsigned ACC_W  = 34
) (
    input  logic signed [ACC_W-1:0]  acc_in,
    output logic signed [DATA_W-1:0] q_out
);
    localparam logic signed [ACC_W-1:0] HALF_LSB = {{(ACC_W-1){1'b0}}, 1'b1} << (FRAC_W-1);
    localparam logic signed [ACC_W-1:0] MAX_V = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MIN_V = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    logic signed [ACC_W-1:0] rnd;
    logic signed [ACC_W-1:0] shr;

    always_comb begin
        rnd = acc_in + HALF_LSB;
        shr = rnd >>> FRAC_W;
        if (shr > MAX_V) begin
            q_out = MAX_V[DATA_W-1:0];
        end else if (shr < MIN_V) begin
            q_out = MIN_V[DATA_W-1:0];
        end else begin
            q_out = shr[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/biquad_tf_top.sv
module biquad_tf_top #(
    parameter int unsigned DATA_W  = biquad_pkg::DEF_DATA_W,
    parameter int unsigned FRAC_W  = biquad_pkg::DEF_FRAC_W,
    parameter int unsigned GUARD_W = biquad_pkg::DEF_GUARD_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_vld,
    input  logic signed [DATA_W-1:0] x_in,
    input  logic signed [DATA_W-1:0] ff0_c,
    input  logic signed [DATA_W-1:0] ff1_c,
    input  logic signed [DATA_W-1:0] ff2_c,
    input  logic signed [DATA_W-1:0] fb1_c,
    input  logic signed [DATA_W-1:0] fb2_c,
    output logic signed [DATA_W-1:0] y_out
);
    localparam int unsigned ACC_W = 2 * DATA_W + GUARD_W;
    localparam logic signed [ACC_W-1:0] ACC_ZERO = '0;

    logic signed [ACC_W-1:0]  st1_q, st2_q;
    logic signed [ACC_W-1:0]  y_sum, t1, st1_d, t2, st2_d;
    logic signed [DATA_W-1:0] y_sat;

    // Output sum: ff0*x + st1
    biquad_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W), .NEGATE(1'b0)) u_mac_y (
        .op_a(ff0_c), .op_b(x_in), .addend(st1_q), .acc_out(y_sum));

    biquad_quant #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_quant (
        .acc_in(y_sum), .q_out(y_sat));

    // First state: ff1*x + st2 - fb1*y
    biquad_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W), .NEGATE(1'b0)) u_mac_f1 (
        .op_a(ff1_c), .op_b(x_in), .addend(st2_q), .acc_out(t1));
    biquad_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W), .NEGATE(1'b1)) u_mac_b1 (
        .op_a(fb1_c), .op_b(y_sat), .addend(t1), .acc_out(st1_d));

    // Second state: ff2*x - fb2*y
    biquad_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W), .NEGATE(1'b0)) u_mac_f2 (
        .op_a(ff2_c), .op_b(x_in), .addend(ACC_ZERO), .acc_out(t2));
    biquad_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W), .NEGATE(1'b1)) u_mac_b2 (
        .op_a(fb2_c), .op_b(y_sat), .addend(t2), .acc_out(st2_d));

    always_ff @(posedge clk) begin
        if (rst) begin
            st1_q <= '0;
            st2_q <= '0;
            y_out <= '0;
        end else if (in_vld) begin
            st1_q <= st1_d;
            st2_q <= st2_d;
            y_out <= y_sat;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (y_out == '0 && st1_q == '0 && st2_q == '0));

    // R6
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(y_out) && $stable(st1_q) && $stable(st2_q)));

    // R3
    rest_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && x_in == '0 && st1_q == '0 && st2_q == '0)
        |=> (y_out == '0 && st1_q == '0 && st2_q == '0));

    // R5
    sat_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && y_sum > ACC_ZERO) |=> !y_out[DATA_W-1]);
endmodule

// File: tb/sim_biquad_tf_top.sv
module sim_biquad_tf_top;
    logic clk = 1'b0;
    logic rst, in_vld;
    logic signed [15:0] x_in, ff0_c, ff1_c, ff2_c, fb1_c, fb2_c;
    logic signed [15:0] y_out;

    int n_chk = 0;
    int n_fail = 0;
    longint m_s1 = 0, m_s2 = 0;
    longint m_y = 0;

    always #2 clk = ~clk;

    biquad_tf_top u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .x_in(x_in),
        .ff0_c(ff0_c), .ff1_c(ff1_c), .ff2_c(ff2_c),
        .fb1_c(fb1_c), .fb2_c(fb2_c), .y_out(y_out));

    function automatic longint q15(input longint v);
        longint r;
        r = (v + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    task automatic set_coef(input int b0, input int b1, input int b2, input int a1, input int a2);
        ff0_c = 16'(b0); ff1_c = 16'(b1); ff2_c = 16'(b2);
        fb1_c = 16'(a1); fb2_c = 16'(a2);
    endtask

    // Called just after a falling edge: drive, update model, check at next falling edge
    task automatic cyc(input bit r, input bit v, input int x, input string req);
        longint ys, b0, b1, b2, a1, a2, xs;
        rst = r; in_vld = v; x_in = 16'(x);
        xs = longint'(x_in); b0 = longint'(ff0_c); b1 = longint'(ff1_c);
        b2 = longint'(ff2_c); a1 = longint'(fb1_c); a2 = longint'(fb2_c);
        ys = q15(b0 * xs + m_s1);
        if (r) begin
            m_s1 = 0; m_s2 = 0; m_y = 0;
        end else if (v) begin
            m_s1 = b1 * xs - a1 * ys + m_s2;
            m_s2 = b2 * xs - a2 * ys;
            m_y  = ys;
        end
        @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (longint'(y_out) != m_y) begin
            n_fail++;
            $display("FAIL %s: y_out actual=%0d expected=%0d", req, y_out, m_y);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all R tags): actual=timeout expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; in_vld = 1'b0; x_in = '0;
        set_coef(0, 0, 0, 0, 0);
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1234, "R1");
        cyc(1'b0, 1'b1, 0, "R1");

        // R4: rounding threshold, ff0 = 1, zero state
        set_coef(1, 0, 0, 0, 0);
        cyc(1'b0, 1'b1, 16384, "R4");
        cyc(1'b0, 1'b1, 16383, "R4");
        cyc(1'b0, 1'b1, -16384, "R4");
        cyc(1'b0, 1'b1, -16385, "R4");

        // R7 / R2 / R3: impulse response through a stable biquad
        cyc(1'b1, 1'b0, 0, "R1");
        set_coef(8192, 16384, 8192, -19661, 9830);
        cyc(1'b0, 1'b1, 32767, "R7");
        for (int i = 0; i < 30; i++) cyc(1'b0, 1'b1, 0, "R7");

        // R6: strobe low while inputs churn
        cyc(1'b0, 1'b1, 20000, "R2");
        for (int i = 0; i < 10; i++) begin
            set_coef(int'($urandom), int'($urandom), int'($urandom), int'($urandom), int'($urandom));
            cyc(1'b0, 1'b0, int'($urandom), "R6");
        end
        set_coef(8192, 16384, 8192, -19661, 9830);
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 0, "R6");

        // R5: positive and negative saturation
        cyc(1'b1, 1'b0, 0, "R1");
        set_coef(-32768, 32767, 0, 0, 0);
        cyc(1'b0, 1'b1, -32768, "R5");
        set_coef(32767, 32767, 0, 0, 0);
        cyc(1'b0, 1'b1, 32767, "R5");
        cyc(1'b0, 1'b1, 32767, "R5");
        cyc(1'b1, 1'b0, 0, "R1");
        set_coef(32767, -32768, 0, 0, 0);
        cyc(1'b0, 1'b1, 32767, "R5");
        set_coef(32767, 0, 0, 0, 0);
        cyc(1'b0, 1'b1, -32768, "R5");

        // R8 / R9: random signed samples, coefficients changing every cycle
        for (int i = 0; i < 400; i++) begin
            set_coef(int'($urandom), int'($urandom), int'($urandom), int'($urandom), int'($urandom));
            cyc(1'b0, ($urandom % 4) != 0, int'($urandom), "R8/R9");
        end

        // R3: mid-run reset then zero input stays at zero
        cyc(1'b1, 1'b1, 5000, "R1");
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 0, "R3");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule